// File: doc/BRIEF.md
# Half-Duplex Medium Access and Collision Backoff Controller

This block decides when a half-duplex transmitter may drive the shared medium. When a frame is pending it waits until carrier sense reports an idle medium and then grants transmission. While the grant is held it watches the collision input. A collision that arrives during the preamble does not cut the preamble short. The controller lets the preamble finish, then drives a jam for a fixed number of bit times. After the jam it waits a random number of slot times, then asks the serializer to restart the same frame.

The random wait follows truncated binary exponential backoff. The range doubles with each collision until it reaches a cap. The random numbers come from a free-running linear feedback shift register. If the frame collides on every attempt up to the limit, the controller gives up. It sets a sticky retry-error flag and pulses a skip signal so that the buffer logic moves on to the next frame. A separate sticky flag reports a frame that runs past the maximum legal length. All timing is counted in bit times: a bit-time tick input advances every counter. Encoding the frame onto the wire is the serializer's job and is not part of this block.

Top module: `csma_backoff_ctl`

## Requirements
- R1: A grant is never issued while carrier sense is high. After a request, tx_grant rises on the clock edge following the first cycle in which carrier is low.
- R2: A collision seen while fewer than PREAMBLE_BITS ticks have been counted under grant leaves tx_grant high. With a tick every cycle, tx_grant stays high for PREAMBLE_BITS+1 cycles in total, and jam_en rises in the cycle right after tx_grant falls.
- R3: A collision seen once at least PREAMBLE_BITS ticks have passed under grant drops tx_grant and raises jam_en on the next clock edge.
- R4: jam_en stays high for exactly JAM_BITS bit ticks. That is JAM_BITS cycles with a tick every cycle, and 2*JAM_BITS-1 or 2*JAM_BITS cycles with a tick every other cycle.
- R5: After the n-th collision of a frame, the backoff lasts k*SLOT_BITS ticks plus one cycle, with 0 <= k <= 2^min(n,BACKOFF_CAP)-1. It ends with a one-cycle retry_req pulse, after which the controller defers again.
- R6: When the MAX_ATTEMPTS-th jam of a frame ends, retry_req is not pulsed. Instead skip_pulse is high for one cycle, retry_err becomes set, and the controller returns to idle without granting again.
- R7: The attempt count goes back to zero when a frame completes (frame_done under grant) or is abandoned. The next frame can then take MAX_ATTEMPTS-1 collisions and still succeed.
- R8: len_err is set when a tick arrives under grant after PREAMBLE_BITS+8*MAX_FRAME_BYTES ticks have already been counted and frame_done is low. A frame ended with frame_done at exactly that count leaves len_err clear. Once set, len_err stays set.
- R9: err_clr clears retry_err and len_err on the next clock edge, unless a new error event occurs in that same cycle.
- R10: After reset all outputs are low. A collision while no grant is held produces no jam and no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One pulse per bit time on the medium |
| tx_req | input | 1 | A frame is ready to be sent |
| carrier | input | 1 | Carrier sense, high while the medium is busy |
| collision | input | 1 | Collision indication from the transceiver |
| frame_done | input | 1 | The serializer has sent the last bit of the frame |
| err_clr | input | 1 | Clears the sticky error flags |
| tx_grant | output | 1 | The serializer may send the preamble and frame |
| jam_en | output | 1 | The serializer must send the jam pattern |
| retry_req | output | 1 | One-cycle pulse: restart the current frame |
| retry_err | output | 1 | Sticky flag: a frame was dropped after too many collisions |
| skip_pulse | output | 1 | One-cycle pulse: drop the current buffer and take the next |
| len_err | output | 1 | Sticky flag: a frame ran past the maximum length |

## Verification
The bench places collisions at three points: at the first bit of the preamble, in the middle of the data, and repeatedly on every grant. This separates the deferred jam from the immediate jam, and a retried frame from an abandoned one. Runs with 3 and 15 collisions followed by success, and with unlimited collisions, tell a correct reset of the attempt count apart from one that carries over between frames. Every measured backoff is checked against the slot granularity and against the truncated range for its collision number. A tick at half rate shows that the jam counts bit times and not clock cycles. Frames that end at the length limit and one bit past it pin down the length-error boundary.

// File: rtl/csma_pkg.sv
// Package csma_pkg
// Holds the types shared by the medium access controller and its helpers.
// Assumes: nothing outside this package.
package csma_pkg;

    // Controller phase: idle, waiting for a quiet medium, sending,
    // jamming after a collision, or waiting out the random backoff.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DEFER   = 3'd1,
        ST_XMIT    = 3'd2,
        ST_JAM     = 3'd3,
        ST_BACKOFF = 3'd4
    } mac_state_t;

endpackage

// File: rtl/csma_lfsr.sv
// Module csma_lfsr
// Galois shift register that steps on every clock, whether or not a draw
// is needed, so the value sampled at a collision depends on history.
// Only the low OUT_W bits are exported.
// Assumes: TAPS is a maximal-length polynomial for width W, SEED is nonzero,
// and OUT_W <= W.
module csma_lfsr #(
    parameter int           W     = 16,
    parameter logic [W-1:0] TAPS  = 16'hB400,
    parameter logic [W-1:0] SEED  = 16'hACE1,
    parameter int           OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);

    logic [W-1:0] sr;

    // Step the register one position per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= SEED;
        end else begin
            sr <= {1'b0, sr[W-1:1]} ^ (sr[0] ? TAPS : '0);
        end
    end

    assign rnd = sr[OUT_W-1:0];

endmodule

// File: rtl/csma_backoff_timer.sv
// Module csma_backoff_timer
// Draws a slot count as the random value masked to min(n, CAP) bits, where
// n is the collision number. It then counts that many slots down, each slot
// being SLOT_BITS bit ticks.
// Assumes: load is a single-cycle strobe, and attempt never exceeds what
// ATT_W bits can hold.
module csma_backoff_timer #(
    parameter int SLOT_BITS = 512,
    parameter int CAP       = 10,
    parameter int ATT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             load,
    input  logic [ATT_W-1:0] attempt,
    input  logic [CAP-1:0]   rnd,
    output logic             expired
);

    localparam int SUB_W = $clog2(SLOT_BITS + 1);

    logic [CAP-1:0]   mask;
    logic [CAP-1:0]   slots_left;
    logic [SUB_W-1:0] sub_cnt;

    // Mask bit i is kept while i is below the collision number; this
    // truncates the exponent at CAP.
    for (genvar i = 0; i < CAP; i++) begin : g_mask
        assign mask[i] = (attempt > ATT_W'(i));
    end

    // Load a fresh slot count, or count ticks down slot by slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_left <= '0;
            sub_cnt    <= '0;
        end else if (load) begin
            slots_left <= rnd & mask;
            sub_cnt    <= '0;
        end else if (bit_tick && (slots_left != '0)) begin
            if (sub_cnt == SUB_W'(SLOT_BITS - 1)) begin
                sub_cnt    <= '0;
                slots_left <= slots_left - 1'b1;
            end else begin
                sub_cnt <= sub_cnt + 1'b1;
            end
        end
    end

    assign expired = (slots_left == '0);

    // R5
    hold_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

endmodule

// File: rtl/csma_backoff_ctl.sv
// Module csma_backoff_ctl
// Medium access controller for a half-duplex transmitter. It defers to
// carrier, grants transmission, completes the preamble before jamming on
// a collision, jams for JAM_BITS bit times, backs off a random number of
// slots, and drops the frame after MAX_ATTEMPTS collisions. It also flags
// frames that run past the maximum length.
// Assumes: bit_tick is a one-cycle pulse per bit time; frame_done is
// asserted only while tx_grant is high; tx_req is sampled only in idle.
module csma_backoff_ctl
    import csma_pkg::*;
#(
    parameter int          PREAMBLE_BITS   = 64,
    parameter int          JAM_BITS        = 32,
    parameter int          SLOT_BITS       = 512,
    parameter int          MAX_ATTEMPTS    = 16,
    parameter int          BACKOFF_CAP     = 10,
    parameter int          MAX_FRAME_BYTES = 1518,
    parameter int          LFSR_W          = 16,
    parameter logic [15:0] LFSR_TAPS       = 16'hB400,
    parameter logic [15:0] LFSR_SEED       = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic tx_req,
    input  logic carrier,
    input  logic collision,
    input  logic frame_done,
    input  logic err_clr,
    output logic tx_grant,
    output logic jam_en,
    output logic retry_req,
    output logic retry_err,
    output logic skip_pulse,
    output logic len_err
);

    localparam int FRAME_LIMIT = PREAMBLE_BITS + MAX_FRAME_BYTES * 8;
    localparam int BIT_W       = $clog2(FRAME_LIMIT + 2);
    localparam int JAM_W       = $clog2(JAM_BITS + 1);
    localparam int ATT_W       = $clog2(MAX_ATTEMPTS + 1);

    mac_state_t             state;
    logic [BIT_W-1:0]       bit_cnt;
    logic                   col_pend;
    logic [JAM_W-1:0]       jam_cnt;
    logic [ATT_W-1:0]       attempts;
    logic [ATT_W-1:0]       att_next;
    logic [BACKOFF_CAP-1:0] rnd;
    logic                   jam_go;
    logic                   jam_done;
    logic                   give_up;
    logic                   bo_load;
    logic                   bo_expired;
    logic                   len_hit;

    csma_lfsr #(
        .W     (LFSR_W),
        .TAPS  (LFSR_W'(LFSR_TAPS)),
        .SEED  (LFSR_W'(LFSR_SEED)),
        .OUT_W (BACKOFF_CAP)
    ) i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    csma_backoff_timer #(
        .SLOT_BITS (SLOT_BITS),
        .CAP       (BACKOFF_CAP),
        .ATT_W     (ATT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .load     (bo_load),
        .attempt  (att_next),
        .rnd      (rnd),
        .expired  (bo_expired)
    );

    // Event decode for the current cycle.
    always_comb begin
        att_next = attempts + 1'b1;
        jam_go   = (state == ST_XMIT) && (collision || col_pend)
                   && (bit_cnt >= BIT_W'(PREAMBLE_BITS));
        jam_done = (state == ST_JAM) && bit_tick
                   && (jam_cnt == JAM_W'(JAM_BITS - 1));
        give_up  = jam_done && (att_next == ATT_W'(MAX_ATTEMPTS));
        bo_load  = jam_done && !give_up;
        len_hit  = (state == ST_XMIT) && !jam_go && bit_tick && !frame_done
                   && (bit_cnt == BIT_W'(FRAME_LIMIT));
    end

    // Phase sequencing together with the bit, jam and attempt counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            col_pend <= 1'b0;
            jam_cnt  <= '0;
            attempts <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (tx_req) state <= ST_DEFER;
                end
                ST_DEFER: begin
                    if (!carrier) begin
                        state    <= ST_XMIT;
                        bit_cnt  <= '0;
                        col_pend <= 1'b0;
                    end
                end
                ST_XMIT: begin
                    if (jam_go) begin
                        state   <= ST_JAM;
                        jam_cnt <= '0;
                    end else if (frame_done) begin
                        state    <= ST_IDLE;
                        attempts <= '0;
                    end else begin
                        if (bit_tick && (bit_cnt != BIT_W'(FRAME_LIMIT + 1)))
                            bit_cnt <= bit_cnt + 1'b1;
                        if (collision) col_pend <= 1'b1;
                    end
                end
                ST_JAM: begin
                    if (give_up) begin
                        state    <= ST_IDLE;
                        attempts <= '0;
                    end else if (jam_done) begin
                        state    <= ST_BACKOFF;
                        attempts <= att_next;
                    end else if (bit_tick) begin
                        jam_cnt <= jam_cnt + 1'b1;
                    end
                end
                ST_BACKOFF: begin
                    if (bo_expired) state <= ST_DEFER;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sticky error flags; a new error event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_err <= 1'b0;
            len_err   <= 1'b0;
        end else begin
            if (give_up)      retry_err <= 1'b1;
            else if (err_clr) retry_err <= 1'b0;
            if (len_hit)      len_err <= 1'b1;
            else if (err_clr) len_err <= 1'b0;
        end
    end

    assign tx_grant   = (state == ST_XMIT);
    assign jam_en     = (state == ST_JAM);
    assign retry_req  = (state == ST_BACKOFF) && bo_expired;
    assign skip_pulse = give_up;

    // R1
    grant_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_grant) |-> !$past(carrier));

    // R2
    preamble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant && (bit_cnt < BIT_W'(PREAMBLE_BITS))) |=> !jam_en);

    // R3
    late_col_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant && collision && (bit_cnt >= BIT_W'(PREAMBLE_BITS))) |=> jam_en);

    // R5
    retry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |=> !retry_req);

    // R6
    skip_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_pulse |=> (retry_err && !tx_grant && !jam_en));

    // R8
    len_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_err && !err_clr) |=> len_err);

endmodule

// File: tb/test_csma_backoff_ctl.sv
// Directed bench for csma_backoff_ctl: one task per scenario, each
// checking its own results at the ports.
module test_csma_backoff_ctl;

    localparam int PRE    = 16;
    localparam int JAM    = 32;
    localparam int SLOT   = 2;
    localparam int MAXATT = 16;
    localparam int CAP    = 10;
    localparam int MAXB   = 8;
    localparam int LIMIT  = PRE + MAXB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b1;
    logic tx_req = 1'b0;
    logic carrier = 1'b0;
    logic collision = 1'b0;
    logic frame_done = 1'b0;
    logic err_clr = 1'b0;
    logic tx_grant, jam_en, retry_req, retry_err, skip_pulse, len_err;
    logic half_rate = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    csma_backoff_ctl #(
        .PREAMBLE_BITS   (PRE),
        .JAM_BITS        (JAM),
        .SLOT_BITS       (SLOT),
        .MAX_ATTEMPTS    (MAXATT),
        .BACKOFF_CAP     (CAP),
        .MAX_FRAME_BYTES (MAXB)
    ) i_csma_backoff_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .tx_req     (tx_req),
        .carrier    (carrier),
        .collision  (collision),
        .frame_done (frame_done),
        .err_clr    (err_clr),
        .tx_grant   (tx_grant),
        .jam_en     (jam_en),
        .retry_req  (retry_req),
        .retry_err  (retry_err),
        .skip_pulse (skip_pulse),
        .len_err    (len_err)
    );

    always #5 clk = ~clk;

    always @(negedge clk) bit_tick <= half_rate ? ~bit_tick : 1'b1;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic start_and_wait_grant();
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        for (int i = 0; i < 10000 && !tx_grant; i++) @(negedge clk);
    endtask

    task automatic finish_frame();
        for (int i = 0; i < 20000 && !tx_grant; i++) @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        @(negedge clk);
    endtask

    // Runs one frame, colliding on the first n_col grants and then sending.
    task automatic run_frame(input int n_col, output int jams, output int retries,
                             output int skips, output int bo_bad);
        int grants = 0;
        int bo_cnt = 0;
        int fin = -1;
        bit in_bo = 0;
        bit prev_jam = 0;
        bit prev_grant = 0;
        bit done = 0;
        jams = 0; retries = 0; skips = 0; bo_bad = 0;
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        for (int guard = 0; guard < 60000 && !done; guard++) begin
            if (prev_jam && !jam_en) begin in_bo = 1; bo_cnt = 0; end
            if (in_bo) bo_cnt++;
            if (retry_req) begin
                int k;
                int lim;
                retries++;
                in_bo = 0;
                k = (bo_cnt - 1) / SLOT;
                lim = (1 << ((jams < CAP) ? jams : CAP)) - 1;
                if (((bo_cnt - 1) % SLOT) != 0 || k > lim || bo_cnt < 1) bo_bad++;
            end
            if (jam_en && !prev_jam) jams++;
            if (skip_pulse) begin skips++; done = 1; end
            collision = 1'b0;
            frame_done = 1'b0;
            if (tx_grant && !prev_grant) begin
                grants++;
                if (grants <= n_col) collision = 1'b1;
                else fin = 5;
            end
            if (fin > 0) begin
                fin--;
                if (fin == 0) frame_done = 1'b1;
            end else if (fin == 0 && !tx_grant) begin
                done = 1;
            end
            prev_jam = jam_en;
            prev_grant = tx_grant;
            @(negedge clk);
        end
        collision = 1'b0;
        frame_done = 1'b0;
    endtask

    task automatic t_reset();
        check(!tx_grant && !jam_en && !retry_req, "R10", "grant/jam/retry after reset",
              {tx_grant, jam_en, retry_req}, 0);
        check(!retry_err && !skip_pulse && !len_err, "R10", "error outputs after reset",
              {retry_err, skip_pulse, len_err}, 0);
    endtask

    task automatic t_idle_collision();
        int seen = 0;
        collision = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (jam_en || tx_grant) seen++;
        end
        collision = 1'b0;
        repeat (3) begin
            @(negedge clk);
            if (jam_en || tx_grant) seen++;
        end
        check(seen == 0, "R10", "jam or grant from idle collision", seen, 0);
    endtask

    task automatic t_defer();
        int early = 0;
        carrier = 1'b1;
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (tx_grant) early++;
            @(negedge clk);
        end
        check(early == 0, "R1", "grant cycles while carrier busy", early, 0);
        carrier = 1'b0;
        @(negedge clk);
        check(tx_grant == 1'b1, "R1", "grant one edge after carrier clears", tx_grant, 1);
        finish_frame();
    endtask

    task automatic t_preamble_collision();
        int g = 0;
        int j = 0;
        start_and_wait_grant();
        while (tx_grant && g < 1000) begin
            g++;
            collision = (g == 4);
            @(negedge clk);
        end
        collision = 1'b0;
        check(g == PRE + 1, "R2", "grant cycles with early collision", g, PRE + 1);
        check(jam_en == 1'b1, "R2", "jam right after preamble", jam_en, 1);
        while (jam_en && j < 1000) begin j++; @(negedge clk); end
        check(j == JAM, "R4", "jam length full-rate tick", j, JAM);
        finish_frame();
    endtask

    task automatic t_late_collision();
        int j = 1;
        start_and_wait_grant();
        repeat (PRE + 10) @(negedge clk);
        collision = 1'b1;
        @(negedge clk);
        collision = 1'b0;
        check(jam_en && !tx_grant, "R3", "jam one edge after late collision",
              {jam_en, tx_grant}, 2);
        @(negedge clk);
        while (jam_en && j < 1000) begin j++; @(negedge clk); end
        check(j == JAM, "R4", "jam length after late collision", j, JAM);
        finish_frame();
    endtask

    task automatic t_half_rate_jam();
        int j = 0;
        half_rate = 1'b1;
        start_and_wait_grant();
        repeat (2 * PRE + 10) @(negedge clk);
        collision = 1'b1;
        @(negedge clk);
        collision = 1'b0;
        while (jam_en && j < 1000) begin j++; @(negedge clk); end
        check(j == 2 * JAM || j == 2 * JAM - 1, "R4", "jam length with half-rate tick",
              j, 2 * JAM);
        finish_frame();
        half_rate = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_retries();
        int jams, retries, skips, bad;
        run_frame(3, jams, retries, skips, bad);
        check(jams == 3 && retries == 3, "R5", "3 collisions give 3 retries", retries, 3);
        check(bad == 0, "R5", "backoff windows out of range (3)", bad, 0);
        check(skips == 0 && !retry_err, "R5", "no skip after 3 collisions", skips, 0);
        run_frame(MAXATT - 1, jams, retries, skips, bad);
        check(skips == 0 && retries == MAXATT - 1, "R7", "count cleared after success",
              retries, MAXATT - 1);
        check(bad == 0, "R5", "backoff windows out of range (15)", bad, 0);
        run_frame(1000, jams, retries, skips, bad);
        check(jams == MAXATT, "R6", "jams before giving up", jams, MAXATT);
        check(retries == MAXATT - 1, "R6", "retry pulses before giving up", retries, MAXATT - 1);
        check(skips == 1, "R6", "skip pulse count", skips, 1);
        check(bad == 0, "R5", "backoff windows out of range (16)", bad, 0);
        @(negedge clk);
        check(retry_err == 1'b1, "R6", "retry error set", retry_err, 1);
        begin
            int g = 0;
            for (int i = 0; i < 10; i++) begin
                if (tx_grant || jam_en) g++;
                @(negedge clk);
            end
            check(g == 0, "R6", "no activity after abandon", g, 0);
        end
        run_frame(MAXATT - 1, jams, retries, skips, bad);
        check(skips == 0 && retries == MAXATT - 1, "R7", "count cleared after abandon",
              skips, 0);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check(retry_err == 1'b0, "R9", "retry error cleared", retry_err, 0);
    endtask

    task automatic t_length();
        start_and_wait_grant();
        repeat (LIMIT) @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        check(len_err == 1'b0, "R8", "frame at length limit", len_err, 0);
        start_and_wait_grant();
        repeat (LIMIT + 1) @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        check(len_err == 1'b1, "R8", "frame one bit over limit", len_err, 1);
        repeat (5) @(negedge clk);
        check(len_err == 1'b1, "R8", "length error stays set", len_err, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check(len_err == 1'b0, "R9", "length error cleared", len_err, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_collision();
        t_defer();
        t_preamble_collision();
        t_late_collision();
        t_half_rate_jam();
        t_length();
        t_retries();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule